// File: doc/BRIEF.md
# Differential SAR conversion controller

This block is the synchronous sequencer for an 8-bit differential charge-redistribution converter that works by successive approximation. A start request begins a conversion. The block first runs a one-cycle purge phase, in which every capacitor plate is grounded. It then runs a one-cycle sampling phase, in which the bottom plates take the input and the top plates take the common-mode level. After that it runs one bit period per bit, starting with the most significant bit.

A one-hot select vector marks the bit that is being decided. Each select bit feeds a drive register for the positive array. A drive register is set when its select bit rises. When its select bit falls, the register keeps its value only if the comparator reported high. The negative array always receives the complement of the positive drive bits. When the last bit is resolved, the drive register holds the result code and a done flag pulses for one cycle.

The analog arrays, the switches and the comparator sit outside this block. The comparator reaches the block as a single decision bit, `cmp_hi`, which is high when the input is at or above the trial level.

Top module: `sar_ctrl_top`

## Requirements
- R1: A synchronous active-high reset clears the select vector, the drive bits, `purge`, `sample` and `done`.
- R2: A start request sampled while idle makes `purge` high for exactly the next clock cycle.
- R3: `sample` is high for exactly the cycle that follows the purge cycle.
- R4: In the cycle after sampling, `bit_sel` equals 8'b1000_0000. It then shifts one position toward bit 0 on each cycle, so that at most one bit is high, and it clears after bit 0.
- R5: During the MSB period, `drv_pos` equals 8'b1000_0000: only the largest weight is driven high.
- R6: During the period of bit i, bit i of `drv_pos` is high, every lower bit is low, and every higher bit holds its resolved value.
- R7: When a bit period ends, that drive bit stays high if `cmp_hi` was high in that period, and is cleared otherwise.
- R8: `drv_neg` is the bitwise complement of `drv_pos` in every cycle.
- R9: `done` is high for one cycle, exactly 10 cycles after the edge that accepted the start. At that point `code` equals floor(Vin·256/Vref), limited to 255, for an ideal comparator.
- R10: A start request that arrives while a conversion is running has no effect: the timing and the code stay unchanged, and no new purge follows.
- R11: `code` keeps its value after `done` until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, sampled on the clock edge |
| cmp_hi | input | 1 | Comparator decision: 1 means the input is at or above the trial level |
| purge | output | 1 | Grounds both plates of all capacitors |
| sample | output | 1 | Connects the input to the bottom plates and the common-mode level to the top plates |
| bit_sel | output | 8 | One-hot select for the bit under decision |
| drv_pos | output | 8 | Drive for the positive array (1 = positive reference) |
| drv_neg | output | 8 | Drive for the negative array, the complement of `drv_pos` |
| code | output | 8 | Conversion result |
| done | output | 1 | One-cycle pulse when `code` is valid |

## Verification
The hardest case to reach from the ports is the set of decision patterns in which each drive bit is both kept and dropped while the lower bits are still under trial. Codes near 0, near full scale and at alternating-bit values are needed to prove that a clear hits only its own bit. The bench computes the comparator answer from a stored input level against the live drive bits. It draws random levels from a fixed seed and adds directed levels at 0, full scale, above full scale and exact code boundaries. A mid-conversion start request is injected on a random subset of the runs to show that it is ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PURGE  = 2'd1,
    PH_SAMPLE = 2'd2,
    PH_CYCLE  = 2'd3
  } sar_phase_e;

  // next select vector: load the top bit, or shift one place toward bit 0
  function automatic logic [7:0] sel_step(input logic [7:0] cur, input logic load);
    logic [7:0] r;
    if (load) r = 8'b1000_0000;
    else      r = cur >> 1;
    return r;
  endfunction

  // resolved value of a drive bit at the end of its period
  function automatic logic resolve_bit(input logic cur, input logic cmp);
    return cur & cmp;
  endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             accept,
  output logic             purge,
  output logic             sample,
  output logic [NBITS-1:0] sel_q,
  output logic [NBITS-1:0] sel_d,
  output logic             last_close
);
  localparam int MSB = NBITS - 1;

  sar_phase_e ph_q, ph_d;

  assign accept     = (ph_q == PH_IDLE) && start;
  assign last_close = (ph_q == PH_CYCLE) && sel_q[0];

  always_comb begin
    ph_d  = ph_q;
    sel_d = sel_q;
    unique case (ph_q)
      PH_IDLE:   if (start) ph_d = PH_PURGE;
      PH_PURGE:  ph_d = PH_SAMPLE;
      PH_SAMPLE: begin
        ph_d  = PH_CYCLE;
        sel_d = NBITS'(sel_step(8'(sel_q), 1'b1) >> (8 - NBITS));
      end
      PH_CYCLE: begin
        sel_d = sel_q >> 1;
        if (sel_q[0]) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      sel_q <= '0;
    end else begin
      ph_q  <= ph_d;
      sel_q <= sel_d;
    end
  end

  assign purge  = (ph_q == PH_PURGE);
  assign sample = (ph_q == PH_SAMPLE);

  p_onehot_r4: assert property (@(posedge clk) disable iff (rst) $onehot0(sel_q));
  p_purge_len_r2: assert property (@(posedge clk) disable iff (rst) purge |=> !purge);
  p_purge_then_sample_r3: assert property (@(posedge clk) disable iff (rst) purge |=> sample);
  p_sample_then_msb_r4: assert property (@(posedge clk) disable iff (rst) sample |=> sel_q[MSB]);
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE) && !last_close |=> !purge);

  for (genvar i = 1; i < NBITS; i++) begin : g_shift
    p_shift_r4: assert property (@(posedge clk) disable iff (rst) sel_q[i] |=> sel_q[i-1]);
  end
endmodule

// File: rtl/sar_drive.sv
module sar_drive
  import sar_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             cmp_hi,
  input  logic [NBITS-1:0] sel_q,
  input  logic [NBITS-1:0] sel_d,
  output logic [NBITS-1:0] drv
);
  localparam int MSB = NBITS - 1;

  logic [NBITS-1:0] bit_open, bit_close;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign bit_open[i]  = sel_d[i] & ~sel_q[i];
    assign bit_close[i] = sel_q[i] & ~sel_d[i];

    always_ff @(posedge clk) begin
      if (rst || clear)       drv[i] <= 1'b0;
      else if (bit_open[i])   drv[i] <= 1'b1;
      else if (bit_close[i])  drv[i] <= resolve_bit(drv[i], cmp_hi);
    end

    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
      bit_close[i] |=> (drv[i] == $past(cmp_hi)));
    p_trial_r6: assert property (@(posedge clk) disable iff (rst)
      sel_q[i] |-> (drv[i] && ((drv & ((NBITS'(1) << i) - NBITS'(1))) == '0)));
  end

  p_msb_trial_r5: assert property (@(posedge clk) disable iff (rst)
    sel_q[MSB] |-> (drv == (NBITS'(1) << MSB)));
endmodule

// File: rtl/sar_ctrl_top.sv
module sar_ctrl_top
  import sar_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_hi,
  output logic             purge,
  output logic             sample,
  output logic [NBITS-1:0] bit_sel,
  output logic [NBITS-1:0] drv_pos,
  output logic [NBITS-1:0] drv_neg,
  output logic [NBITS-1:0] code,
  output logic             done
);
  logic             accept, last_close;
  logic [NBITS-1:0] sel_q, sel_d, drv;
  logic             done_q;

  sar_seq #(.NBITS(NBITS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .accept(accept),
    .purge(purge), .sample(sample), .sel_q(sel_q), .sel_d(sel_d),
    .last_close(last_close)
  );

  sar_drive #(.NBITS(NBITS)) u_drv (
    .clk(clk), .rst(rst), .clear(accept), .cmp_hi(cmp_hi),
    .sel_q(sel_q), .sel_d(sel_d), .drv(drv)
  );

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= last_close;
  end

  assign bit_sel = sel_q;
  assign drv_pos = drv;
  assign drv_neg = ~drv;
  assign code    = drv;
  assign done    = done_q;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst) done |-> (sel_q == '0) && !purge && !sample);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> $stable(code));
endmodule

// File: tb/sar_ctrl_top_test.sv
`timescale 1ns/1ps
module sar_ctrl_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       cmp_hi;
  logic       purge, sample, done;
  logic [7:0] bit_sel, drv_pos, drv_neg, code;

  int unsigned vin_mv = 0;
  localparam int unsigned VREF_MV = 1000;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // ideal comparator against the live positive drive bits
  always_comb cmp_hi = (vin_mv * 256) >= (32'(drv_pos) * VREF_MV);

  sar_ctrl_top uut (
    .clk(clk), .rst(rst), .start(start), .cmp_hi(cmp_hi),
    .purge(purge), .sample(sample), .bit_sel(bit_sel),
    .drv_pos(drv_pos), .drv_neg(drv_neg), .code(code), .done(done)
  );

  function automatic logic [7:0] ideal_code(input int unsigned mv);
    int unsigned q = (mv * 256) / VREF_MV;
    return (q > 255) ? 8'd255 : q[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic convert(input int unsigned mv, input bit inject);
    logic [7:0] exp, trial, prev;
    exp = ideal_code(mv);
    vin_mv = mv;
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(purge == 1'b1 && sample == 1'b0, "R2", {purge, sample}, 2'b10);
    tick();
    chk(sample == 1'b1 && purge == 1'b0, "R3", {purge, sample}, 2'b01);
    for (int i = 7; i >= 0; i--) begin
      tick();
      if (inject && i == 4) start = 1'b1;
      if (inject && i == 3) start = 1'b0;
      chk(bit_sel == (8'd1 << i), "R4", bit_sel, 8'd1 << i);
      trial = (exp & ~((8'd2 << i) - 8'd1)) | (8'd1 << i);
      if (i == 7) chk(drv_pos == 8'h80, "R5", drv_pos, 8'h80);
      chk(drv_pos == trial, "R6 R7", drv_pos, trial);
      chk(drv_neg == ~drv_pos, "R8", drv_neg, ~drv_pos);
    end
    start = 1'b0;
    tick();
    chk(done == 1'b1, "R9 done", done, 1);
    chk(code == exp, "R9 code", code, exp);
    chk(bit_sel == 8'd0, "R4 clear", bit_sel, 0);
    prev = code;
    tick();
    chk(done == 1'b0, "R9 pulse", done, 0);
    tick();
    chk(code == prev && purge == 1'b0, inject ? "R10 R11" : "R11", code, prev);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bit_sel == 0 && drv_pos == 0 && !purge && !sample && !done, "R1",
        {bit_sel, drv_pos}, 0);
    convert(0, 0);
    convert(999, 0);
    convert(1000, 1);
    convert(500, 0);
    convert(665, 1);
    convert(4, 0);
    convert(3, 0);
    for (int n = 0; n < 40; n++) convert($urandom % 1001, ($urandom % 3) == 0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    @(negedge clk);
    chk(code == 0 && bit_sel == 0 && !done && !purge, "R1 mid", code, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule